// File: doc/BRIEF.md
# Chained Three-Channel Result Mover

This block copies converter result registers into working memory after each measurement scan. It has three channels, one for each converter. A scan-done pulse starts channel 0. Channel 0 reads five 16-bit results from converter 0 and writes them out. When it finishes, it starts channel 1 for converter 1, and channel 1 in turn starts channel 2 for converter 2. Only the end of channel 2 raises an interrupt to the processor, so the control routine runs once, when all fifteen results are in place.

Destination addresses are interleaved so that the three phase currents of one motor sit next to each other. Converter k writes element [motor][k]. Each motor slot is 8 bytes wide, so a single wide load can fetch the whole slot. On the read side, each channel walks a five-register window with a 4-byte step inside a 32-byte circular region. The window may start anywhere in that region and wraps at its end. The block moves one result per clock. The read port is combinational, so every beat reads and writes in the same cycle.

Top module: `res_chain_mover`

## Requirements
- R1: While reset is held and after it is released with no trigger, `busy` is 0, `irq` is 0, `overrun_err` is 0, and `src_rd_en` and `mem_wr_en` are 0.
- R2: When `scan_done` is sampled high at a clock edge while no channel is busy, channel 0 performs its first beat in the cycle that follows. A beat is `src_rd_en` = `mem_wr_en` = 1. The chain then performs one beat per cycle.
- R3: Channel 1's first beat follows channel 0's fifth beat in the very next cycle, and channel 2 follows channel 1 in the same way. A full chain is 15 consecutive beats.
- R4: For beat i (0..4) of channel c, `src_rd_addr` = SRC_BASE + c*SRC_CONV_STRIDE + ((SRC_START + 4*i) mod 32).
- R5: For beat i of channel c, `mem_wr_addr` = DST_BASE + ((8*i + 2*c) mod DST_WRAP). These are byte addresses of 16-bit elements, so the address is always even.
- R6: `mem_wr_data` equals `src_rd_data` in the same beat.
- R7: `busy[c]` is 1 exactly during the beats of channel c, and at most one bit of `busy` is set at any time.
- R8: `irq` is a one-cycle pulse in the cycle right after channel 2's last beat. No other channel's completion drives it.
- R9: A `scan_done` sampled while any channel is busy is refused. It sets `overrun_err`, which stays set until reset. The running chain continues with the same beats and addresses.
- R10: After a chain completes, the next accepted scan again starts at the base addresses of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_done | input | 1 | Scan-complete request from converter 0 |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | ADDR_W | Source byte address |
| src_rd_data | input | DATA_W | Source read data, valid in the same cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory byte address |
| mem_wr_data | output | DATA_W | Memory write data |
| busy | output | NUM_CH | One-hot active-channel flags |
| irq | output | 1 | Chain-complete interrupt pulse |
| overrun_err | output | 1 | Sticky refused-trigger flag |

## Verification
Each accepted trigger is driven so that it is sampled at exactly one clock edge. The first beat is due in the cycle right after that edge. Beat k of the chain is due k cycles later, and the interrupt is due 15 cycles after the first beat. The bench compares every beat against a table of expected source and destination addresses at the falling edge of its own cycle. It checks the interrupt in the 16th cycle and again one cycle later, to confirm that it is a single pulse. For the overrun case, a trigger is injected in the middle of a chain, and the remaining beats are checked at their unshifted cycles.

// File: rtl/mover_pkg.sv
package mover_pkg;
    localparam int DEF_NUM_CH  = 3;
    localparam int DEF_NUM_RES = 5;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_ADDR_W  = 16;

    typedef struct packed {
        logic irq;
        logic err;
    } mover_flags_t;
endpackage

// File: rtl/mover_seq.sv
module mover_seq #(
    parameter int NUM_CH  = mover_pkg::DEF_NUM_CH,
    parameter int NUM_RES = mover_pkg::DEF_NUM_RES,
    localparam int CH_W   = $clog2(NUM_CH > 1 ? NUM_CH : 2),
    localparam int IDX_W  = $clog2(NUM_RES > 1 ? NUM_RES : 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic              beat_valid,
    output logic [CH_W-1:0]   beat_ch,
    output logic [IDX_W-1:0]  beat_idx,
    output logic [NUM_CH-1:0] ch_busy,
    output logic              chain_done,
    output logic              refused
);
    typedef struct packed {
        logic             active;
        logic [CH_W-1:0]  ch;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;
    logic last_idx, last_ch;

    always_comb begin
        st_d     = st_q;
        last_idx = (st_q.idx == IDX_W'(NUM_RES - 1));
        last_ch  = (st_q.ch == CH_W'(NUM_CH - 1));
        if (st_q.active) begin
            if (last_idx) begin
                st_d.idx = '0;
                if (last_ch) begin
                    st_d.active = 1'b0;
                    st_d.ch     = '0;
                end else begin
                    st_d.ch = st_q.ch + CH_W'(1);
                end
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end else if (start_req) begin
            st_d.active = 1'b1;
            st_d.ch     = '0;
            st_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_valid = st_q.active;
    assign beat_ch    = st_q.ch;
    assign beat_idx   = st_q.idx;
    assign chain_done = st_q.active && last_idx && last_ch;
    assign refused    = start_req && st_q.active;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_busy
        assign ch_busy[g] = st_q.active && (st_q.ch == CH_W'(g));
    end

    AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_busy)); // R7
    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && ch_busy == '0) |=> ch_busy[0]); // R2
    AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_busy[0] && beat_idx == IDX_W'(NUM_RES - 1)) |=> ch_busy[1]); // R3
endmodule

// File: rtl/mover_addr.sv
module mover_addr #(
    parameter int NUM_CH          = mover_pkg::DEF_NUM_CH,
    parameter int NUM_RES         = mover_pkg::DEF_NUM_RES,
    parameter int ADDR_W          = mover_pkg::DEF_ADDR_W,
    parameter int DATA_W          = mover_pkg::DEF_DATA_W,
    parameter int SRC_BASE        = 'h1000,
    parameter int SRC_CONV_STRIDE = 'h100,
    parameter int SRC_START       = 0,
    parameter int SRC_STEP        = 4,
    parameter int SRC_WRAP        = 32,
    parameter int DST_BASE        = 'h2000,
    parameter int MOTOR_STRIDE    = 8,
    parameter int DST_WRAP        = 64,
    localparam int CH_W           = $clog2(NUM_CH > 1 ? NUM_CH : 2),
    localparam int IDX_W          = $clog2(NUM_RES > 1 ? NUM_RES : 2),
    localparam int ELEM_BYTES     = DATA_W / 8
) (
    input  logic [CH_W-1:0]   ch,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    logic [ADDR_W-1:0] src_base_tab [NUM_CH];
    logic [ADDR_W-1:0] dst_lane_tab [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign src_base_tab[g] = ADDR_W'(SRC_BASE + g * SRC_CONV_STRIDE);
        assign dst_lane_tab[g] = ADDR_W'(g * ELEM_BYTES);
    end

    logic [ADDR_W-1:0] src_off, dst_off, sel_src_base, sel_lane;

    always_comb begin
        sel_src_base = src_base_tab[0];
        sel_lane     = dst_lane_tab[0];
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch == CH_W'(c)) begin
                sel_src_base = src_base_tab[c];
                sel_lane     = dst_lane_tab[c];
            end
        end
        src_off  = (ADDR_W'(SRC_START) + ADDR_W'(idx) * ADDR_W'(SRC_STEP))
                   & ADDR_W'(SRC_WRAP - 1);
        dst_off  = (ADDR_W'(idx) * ADDR_W'(MOTOR_STRIDE) + sel_lane)
                   & ADDR_W'(DST_WRAP - 1);
        src_addr = sel_src_base + src_off;
        dst_addr = ADDR_W'(DST_BASE) + dst_off;
    end
endmodule

// File: rtl/mover_flags.sv
module mover_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic chain_done,
    input  logic refused,
    output logic irq,
    output logic overrun_err
);
    import mover_pkg::*;

    mover_flags_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.irq = chain_done;
        fl_d.err = fl_q.err | refused;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign irq         = fl_q.irq;
    assign overrun_err = fl_q.err;

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
endmodule

// File: rtl/res_chain_mover.sv
module res_chain_mover #(
    parameter int NUM_CH          = mover_pkg::DEF_NUM_CH,
    parameter int NUM_RES         = mover_pkg::DEF_NUM_RES,
    parameter int DATA_W          = mover_pkg::DEF_DATA_W,
    parameter int ADDR_W          = mover_pkg::DEF_ADDR_W,
    parameter int SRC_BASE        = 'h1000,
    parameter int SRC_CONV_STRIDE = 'h100,
    parameter int SRC_START       = 0,
    parameter int SRC_STEP        = 4,
    parameter int SRC_WRAP        = 32,
    parameter int DST_BASE        = 'h2000,
    parameter int MOTOR_STRIDE    = 8,
    parameter int DST_WRAP        = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_done,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic [DATA_W-1:0] src_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [NUM_CH-1:0] busy,
    output logic              irq,
    output logic              overrun_err
);
    localparam int CH_W  = $clog2(NUM_CH > 1 ? NUM_CH : 2);
    localparam int IDX_W = $clog2(NUM_RES > 1 ? NUM_RES : 2);

    logic             beat_valid, chain_done, refused;
    logic [CH_W-1:0]  beat_ch;
    logic [IDX_W-1:0] beat_idx;

    mover_seq #(.NUM_CH(NUM_CH), .NUM_RES(NUM_RES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(scan_done),
        .beat_valid(beat_valid), .beat_ch(beat_ch), .beat_idx(beat_idx),
        .ch_busy(busy), .chain_done(chain_done), .refused(refused)
    );

    mover_addr #(
        .NUM_CH(NUM_CH), .NUM_RES(NUM_RES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SRC_BASE(SRC_BASE), .SRC_CONV_STRIDE(SRC_CONV_STRIDE),
        .SRC_START(SRC_START), .SRC_STEP(SRC_STEP), .SRC_WRAP(SRC_WRAP),
        .DST_BASE(DST_BASE), .MOTOR_STRIDE(MOTOR_STRIDE), .DST_WRAP(DST_WRAP)
    ) u_addr (
        .ch(beat_ch), .idx(beat_idx),
        .src_addr(src_rd_addr), .dst_addr(mem_wr_addr)
    );

    mover_flags u_flags (
        .clk(clk), .rst_n(rst_n), .chain_done(chain_done), .refused(refused),
        .irq(irq), .overrun_err(overrun_err)
    );

    assign src_rd_en   = beat_valid;
    assign mem_wr_en   = beat_valid;
    assign mem_wr_data = src_rd_data;

    AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(busy[NUM_CH-1]) && busy == '0)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err); // R9
    AST_REFUSE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && busy[0]) |=> (busy[0] || busy[1])); // R9
    AST_DST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !mem_wr_addr[0]); // R5
endmodule

// File: tb/sim_res_chain_mover.sv
module sim_res_chain_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_done = 1'b0;
    logic        src_rd_en, mem_wr_en, irq, overrun_err;
    logic [15:0] src_rd_addr, src_rd_data, mem_wr_addr, mem_wr_data;
    logic [2:0]  busy;
    logic [15:0] salt = 16'h5A5A;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign src_rd_data = src_rd_addr ^ salt;

    res_chain_mover #(.SRC_START(16)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_done(scan_done),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .irq(irq), .overrun_err(overrun_err)
    );

    // Expected beats: source window starts at offset 16 and wraps at 32 (R4),
    // destination element [motor][channel] with 8-byte motor slots (R5).
    localparam logic [15:0] EXP_SRC [15] = '{
        16'h1010, 16'h1014, 16'h1018, 16'h101C, 16'h1000,
        16'h1110, 16'h1114, 16'h1118, 16'h111C, 16'h1100,
        16'h1210, 16'h1214, 16'h1218, 16'h121C, 16'h1200};
    localparam logic [15:0] EXP_DST [15] = '{
        16'h2000, 16'h2008, 16'h2010, 16'h2018, 16'h2020,
        16'h2002, 16'h200A, 16'h2012, 16'h201A, 16'h2022,
        16'h2004, 16'h200C, 16'h2014, 16'h201C, 16'h2024};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Trigger sampled at one edge; beats are checked at falling edges.
    task automatic run_chain(input int inject_at, input bit exp_err);
        @(negedge clk) scan_done = 1'b1;
        @(negedge clk) scan_done = 1'b0;
        for (int k = 0; k < 15; k++) begin
            chk(src_rd_en && mem_wr_en, "R2/R3 beat strobe", {src_rd_en, mem_wr_en}, 2'b11);
            chk(src_rd_addr == EXP_SRC[k], "R4 source address", src_rd_addr, EXP_SRC[k]);
            chk(mem_wr_addr == EXP_DST[k], "R5/R10 dest address", mem_wr_addr, EXP_DST[k]);
            chk(mem_wr_data == (EXP_SRC[k] ^ salt), "R6 data", mem_wr_data, EXP_SRC[k] ^ salt);
            chk(busy == 3'(1 << (k / 5)), "R7 busy", busy, 3'(1 << (k / 5)));
            chk(irq == 1'b0, "R8 no early irq", irq, 0);
            if (k == inject_at) scan_done = 1'b1;
            @(negedge clk) scan_done = 1'b0;
        end
        chk(irq == 1'b1, "R8 irq after channel 2", irq, 1);
        chk(busy == 3'b000 && !mem_wr_en, "R7 idle after chain", {busy, mem_wr_en}, 0);
        chk(overrun_err == exp_err, "R9 overrun flag", overrun_err, exp_err);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq single pulse", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && !irq && !overrun_err && !src_rd_en && !mem_wr_en,
            "R1 reset state", {busy, irq, overrun_err, src_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0 && !irq && !overrun_err && !src_rd_en && !mem_wr_en,
            "R1 idle after reset", {busy, irq, overrun_err, src_rd_en, mem_wr_en}, 0);

        run_chain(-1, 1'b0);
        salt = 16'hC3F0;
        repeat (2) @(negedge clk);
        run_chain(-1, 1'b0);               // R10 addresses restart at base
        salt = 16'h0FF1;
        run_chain(7, 1'b1);                // R9 trigger inside channel 1
        repeat (4) @(negedge clk);
        chk(!mem_wr_en && busy == 0, "R9 refused trigger leaves no chain",
            {mem_wr_en, busy}, 0);
        chk(overrun_err == 1'b1, "R9 flag stays set", overrun_err, 1);

        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk(overrun_err == 1'b0, "R1 reset clears flag", overrun_err, 0);
        salt = 16'h1234;
        run_chain(-1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule